// File: doc/BRIEF.md
# Triggered pulse output port

This block drives eight output pins, split into two groups of four, from data bits that a processor has stored in two 8-bit control registers. Storing data does not move the pins. A bit reaches its pin only when the event that owns that pin occurs. Group 0, and in one mode the low half of group 1, are loaded on a pulse output trigger. The high half of group 1, and in the other mode its low half too, are loaded on a timer underflow strobe.

The pulse output trigger comes from one of two sources. One is an internal single-cycle strobe. The other is an asynchronous external pin, which is synchronised and edge-detected before use. A global polarity bit inverts the pins, but in mode 1 the two high pins of group 1 are exempt from inversion. Three enable bits choose which of the low group-0 pins are gated by an external PWM waveform. These enables take effect only at the next pulse output trigger.

The timer, the PWM generator and pin direction control sit outside the block and appear only as inputs.

Top module: `trig_pulse_port`

## Requirements
- R1: After reset, both registers and all eight pins are 0, and the pins stay 0 until the first load event.
- R2: Register A bits 7:6 select the pulse output trigger. 00 selects the internal strobe `int_trig`. 01 selects a rising edge of `ext_trig_pin`, 10 a falling edge, and 11 either edge. The external pin passes through a two-flop synchroniser. A source that is not selected has no effect on the pins.
- R3: On a pulse output trigger, group-0 pin k is loaded from register A bit k (k = 0..3). Without a trigger, group 0 holds its value.
- R4: In mode 1 (`mode_sel`=1), group-1 pins 1:0 are loaded from register A bits 5:4 on a pulse output trigger. In this mode the underflow strobe and register B bits 5:4 do not change these pins.
- R5: In mode 0, group-1 pins 1:0 are loaded from register B bits 5:4 on the underflow strobe. In this mode a pulse output trigger and register A bits 5:4 do not change these pins.
- R6: In both modes, group-1 pins 3:2 are loaded from register B bits 7:6 on each underflow strobe, and a pulse output trigger does not change them.
- R7: Register B bit 3 set inverts every pin in mode 0. In mode 1 it inverts every pin except group-1 pins 3:2. A change of this bit or of the mode shows on the pins one cycle after the edge that stores it.
- R8: Register B bit k (k = 0..2) enables PWM gating of group-0 pin k. An enabled pin drives its latched bit ANDed with `pwm_wave`, and inversion is applied after this gating. The enables in use are the ones captured at the last pulse output trigger.
- R9: Writing new PWM enable bits does not change the gating until a pulse output trigger occurs.
- R10: Writing new data bits to either register does not change any pin until the matching load event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_a_we | input | 1 | Store `wr_data` into register A |
| reg_b_we | input | 1 | Store `wr_data` into register B |
| wr_data | input | 8 | Write data for the control registers |
| mode_sel | input | 1 | Operating mode (0 or 1) |
| int_trig | input | 1 | Internal trigger strobe, one cycle wide |
| ext_trig_pin | input | 1 | Asynchronous external trigger pin |
| tmr_uf | input | 1 | Timer underflow strobe, one cycle wide |
| pwm_wave | input | 1 | External PWM waveform |
| grp0_pins | output | 4 | Pin group 0 |
| grp1_pins | output | 4 | Pin group 1 |

## Verification
Each result has its own latency, so the bench checks each one at its due cycle. An `int_trig` or `tmr_uf` strobe sampled at clock edge E shows on the pins after edge E+1. A change of `ext_trig_pin` before edge E shows after edge E+3, counting two synchroniser stages, the edge register and the output register. A register write, a mode change or a `pwm_wave` change shows after the next edge following the edge that captures it. The bench drives and samples on the falling clock edge and counts exactly that many falling edges before each comparison. For cases where something must not happen, it first waits at least as long as the longest of these latencies and then compares the pins against the value they held before.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int REG_W  = 8;
  localparam int GRP_W  = 4;
  localparam int HALF_W = GRP_W / 2;
  localparam int PWM_N  = 3;

  typedef enum logic [1:0] {
    TSEL_INT  = 2'b00,
    TSEL_RISE = 2'b01,
    TSEL_FALL = 2'b10,
    TSEL_BOTH = 2'b11
  } trig_sel_e;

  // Register A layout: [7:6] trigger select, [5:4] group-1 low data (mode 1), [3:0] group-0 data
  typedef struct packed {
    trig_sel_e          tsel;
    logic [HALF_W-1:0]  g1lo;
    logic [GRP_W-1:0]   g0;
  } reg_a_t;

  // Register B layout: [7:6] group-1 high data, [5:4] group-1 low data (mode 0), [3] invert, [2:0] PWM enables
  typedef struct packed {
    logic [HALF_W-1:0]  g1hi;
    logic [HALF_W-1:0]  g1lo;
    logic               inv;
    logic [PWM_N-1:0]   pwm_en;
  } reg_b_t;
endpackage

// File: rtl/tpp_regs.sv
module tpp_regs
  import tpp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             a_we,
  input  logic             b_we,
  input  logic [REG_W-1:0] wdata,
  output reg_a_t           reg_a,
  output reg_b_t           reg_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (a_we) reg_a <= reg_a_t'(wdata);
      if (b_we) reg_b <= reg_b_t'(wdata);
    end
  end
endmodule

// File: rtl/tpp_trig.sv
module tpp_trig
  import tpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic      clk,
  input  logic      rst,
  input  trig_sel_e tsel,
  input  logic      int_trig,
  input  logic      ext_pin,
  output logic      trig
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= ext_pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (tsel)
      TSEL_INT:  trig = int_trig;
      TSEL_RISE: trig = rise;
      TSEL_FALL: trig = fall;
      TSEL_BOTH: trig = rise | fall;
      default:   trig = 1'b0;
    endcase
  end

  // R2: a rising-edge trigger is a single-cycle pulse
  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    (tsel == TSEL_RISE && trig) |=> !rise);
endmodule

// File: rtl/tpp_latch.sv
module tpp_latch
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              trig,
  input  logic              uf,
  input  logic [GRP_W-1:0]  a_g0,
  input  logic [HALF_W-1:0] a_g1lo,
  input  logic [HALF_W-1:0] b_g1lo,
  input  logic [HALF_W-1:0] b_g1hi,
  input  logic [PWM_N-1:0]  b_pwm_en,
  output logic [GRP_W-1:0]  g0_lat,
  output logic [GRP_W-1:0]  g1_lat,
  output logic [PWM_N-1:0]  en_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      g0_lat <= '0;
      g1_lat <= '0;
      en_lat <= '0;
    end else begin
      if (trig) begin
        g0_lat <= a_g0;
        en_lat <= b_pwm_en;
        if (mode) g1_lat[HALF_W-1:0] <= a_g1lo;
      end
      if (uf) begin
        g1_lat[GRP_W-1:HALF_W] <= b_g1hi;
        if (!mode) g1_lat[HALF_W-1:0] <= b_g1lo;
      end
    end
  end

  // R3: group 0 holds without a trigger
  p_g0_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(g0_lat));
  // R6: underflow loads high half of group 1 from register B
  p_g1hi_load_r6: assert property (@(posedge clk) disable iff (rst)
    uf |=> g1_lat[GRP_W-1:HALF_W] == $past(b_g1hi));
  // R5: in mode 0 the low half of group 1 moves only on underflow
  p_g1lo_mode0_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode && !uf) |=> $stable(g1_lat[HALF_W-1:0]));
  // R9: PWM enables change only at a trigger
  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !trig |=> $stable(en_lat));
endmodule

// File: rtl/tpp_out.sv
module tpp_out
  import tpp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             inv,
  input  logic             pwm_wave,
  input  logic [GRP_W-1:0] g0_lat,
  input  logic [GRP_W-1:0] g1_lat,
  input  logic [PWM_N-1:0] en_lat,
  output logic [GRP_W-1:0] grp0_pins,
  output logic [GRP_W-1:0] grp1_pins
);
  logic [GRP_W-1:0] gated0;
  logic [GRP_W-1:0] inv0, inv1;

  generate
    for (genvar k = 0; k < GRP_W; k++) begin : g_gate
      if (k < PWM_N) begin : g_pwm
        assign gated0[k] = g0_lat[k] & (en_lat[k] ? pwm_wave : 1'b1);
      end else begin : g_plain
        assign gated0[k] = g0_lat[k];
      end
    end
  endgenerate

  assign inv0 = {GRP_W{inv}};
  assign inv1 = {{HALF_W{inv & ~mode}}, {HALF_W{inv}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      grp0_pins <= '0;
      grp1_pins <= '0;
    end else begin
      grp0_pins <= gated0 ^ inv0;
      grp1_pins <= g1_lat ^ inv1;
    end
  end

  // R7: in mode 1 the high half of group 1 is never inverted
  p_mode1_noinv_r7: assert property (@(posedge clk) disable iff (rst)
    mode |=> grp1_pins[GRP_W-1:HALF_W] == $past(g1_lat[GRP_W-1:HALF_W]));
endmodule

// File: rtl/trig_pulse_port.sv
module trig_pulse_port
  import tpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_a_we,
  input  logic             reg_b_we,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mode_sel,
  input  logic             int_trig,
  input  logic             ext_trig_pin,
  input  logic             tmr_uf,
  input  logic             pwm_wave,
  output logic [GRP_W-1:0] grp0_pins,
  output logic [GRP_W-1:0] grp1_pins
);
  reg_a_t           reg_a;
  reg_b_t           reg_b;
  logic             trig;
  logic [GRP_W-1:0] g0_lat, g1_lat;
  logic [PWM_N-1:0] en_lat;

  tpp_regs u_regs (
    .clk(clk), .rst(rst), .a_we(reg_a_we), .b_we(reg_b_we),
    .wdata(wr_data), .reg_a(reg_a), .reg_b(reg_b)
  );

  tpp_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .tsel(reg_a.tsel), .int_trig(int_trig),
    .ext_pin(ext_trig_pin), .trig(trig)
  );

  tpp_latch u_latch (
    .clk(clk), .rst(rst), .mode(mode_sel), .trig(trig), .uf(tmr_uf),
    .a_g0(reg_a.g0), .a_g1lo(reg_a.g1lo), .b_g1lo(reg_b.g1lo),
    .b_g1hi(reg_b.g1hi), .b_pwm_en(reg_b.pwm_en),
    .g0_lat(g0_lat), .g1_lat(g1_lat), .en_lat(en_lat)
  );

  tpp_out u_out (
    .clk(clk), .rst(rst), .mode(mode_sel), .inv(reg_b.inv),
    .pwm_wave(pwm_wave), .g0_lat(g0_lat), .g1_lat(g1_lat), .en_lat(en_lat),
    .grp0_pins(grp0_pins), .grp1_pins(grp1_pins)
  );

  // R1: the first cycle after reset shows all pins low
  p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grp0_pins == '0 && grp1_pins == '0));
endmodule

// File: tb/trig_pulse_port_tb_top.sv
`timescale 1ns/1ps
module trig_pulse_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_a_we = 1'b0, reg_b_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic       mode_sel = 1'b1;
  logic       int_trig = 1'b0, ext_trig_pin = 1'b0, tmr_uf = 1'b0;
  logic       pwm_wave = 1'b1;
  logic [3:0] grp0_pins, grp1_pins;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  trig_pulse_port dut_i (
    .clk(clk), .rst(rst), .reg_a_we(reg_a_we), .reg_b_we(reg_b_we),
    .wr_data(wr_data), .mode_sel(mode_sel), .int_trig(int_trig),
    .ext_trig_pin(ext_trig_pin), .tmr_uf(tmr_uf), .pwm_wave(pwm_wave),
    .grp0_pins(grp0_pins), .grp1_pins(grp1_pins)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_a(input logic [7:0] d);
    reg_a_we = 1'b1; wr_data = d; cyc(1); reg_a_we = 1'b0;
  endtask

  task automatic wr_b(input logic [7:0] d);
    reg_b_we = 1'b1; wr_data = d; cyc(1); reg_b_we = 1'b0;
  endtask

  task automatic pulse_int();
    int_trig = 1'b1; cyc(1); int_trig = 1'b0; cyc(1);
  endtask

  task automatic pulse_uf();
    tmr_uf = 1'b1; cyc(1); tmr_uf = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1", "grp0 after reset", grp0_pins, 4'h0);
    chk("R1", "grp1 after reset", grp1_pins, 4'h0);
  endtask

  task automatic t_int_trigger();
    wr_a(8'h2A);
    ext_trig_pin = 1'b1; cyc(6);
    chk("R2", "ext edge ignored under internal select", grp0_pins, 4'h0);
    pulse_int();
    chk("R3", "grp0 after internal trigger", grp0_pins, 4'hA);
    chk("R4", "grp1 low from A in mode 1", grp1_pins, 4'b0010);
  endtask

  task automatic t_hold();
    wr_a(8'h15); cyc(4);
    chk("R10", "grp0 unchanged after write", grp0_pins, 4'hA);
    chk("R10", "grp1 unchanged after write", grp1_pins, 4'b0010);
  endtask

  task automatic t_ext_rise();
    wr_a(8'h43);
    ext_trig_pin = 1'b0; cyc(6);
    chk("R2", "falling edge ignored under rise select", grp0_pins, 4'hA);
    pulse_int(); cyc(2);
    chk("R2", "internal strobe ignored under rise select", grp0_pins, 4'hA);
    ext_trig_pin = 1'b1; cyc(4);
    chk("R3", "grp0 after external rise", grp0_pins, 4'h3);
    chk("R4", "grp1 low after external rise", grp1_pins, 4'b0000);
  endtask

  task automatic t_ext_fall_both();
    wr_a(8'h8C);
    ext_trig_pin = 1'b0; cyc(4);
    chk("R2", "grp0 after external fall", grp0_pins, 4'hC);
    wr_a(8'hC6);
    ext_trig_pin = 1'b1; cyc(4);
    chk("R2", "grp0 after rise under both", grp0_pins, 4'h6);
    wr_a(8'hC9);
    ext_trig_pin = 1'b0; cyc(4);
    chk("R2", "grp0 after fall under both", grp0_pins, 4'h9);
    wr_a(8'h37); cyc(3);
  endtask

  task automatic t_mode0();
    mode_sel = 1'b0;
    wr_b(8'h60); cyc(2);
    chk("R10", "grp1 unchanged after B write", grp1_pins, 4'b0000);
    pulse_uf();
    chk("R5", "grp1 after underflow in mode 0", grp1_pins, 4'b0110);
    pulse_int();
    chk("R3", "grp0 after trigger in mode 0", grp0_pins, 4'h7);
    chk("R5", "trigger leaves grp1 low in mode 0", grp1_pins, 4'b0110);
  endtask

  task automatic t_mode1_uf();
    mode_sel = 1'b1;
    wr_b(8'hF0);
    pulse_uf();
    chk("R6", "grp1 high from B, low kept in mode 1", grp1_pins, 4'b1110);
    pulse_int();
    chk("R4", "grp1 low from A on trigger", grp1_pins, 4'b1111);
    chk("R6", "grp1 high unchanged by trigger", grp1_pins[3:2], 2'b11);
  endtask

  task automatic t_polarity();
    wr_b(8'hF8); cyc(1);
    chk("R7", "grp0 inverted", grp0_pins, 4'h8);
    chk("R7", "grp1 mode 1 high half not inverted", grp1_pins, 4'b1100);
    mode_sel = 1'b0; cyc(1);
    chk("R7", "grp1 fully inverted in mode 0", grp1_pins, 4'b0000);
    mode_sel = 1'b1;
    wr_b(8'hF0); cyc(1);
    chk("R7", "grp0 restored", grp0_pins, 4'h7);
    chk("R7", "grp1 restored", grp1_pins, 4'b1111);
  endtask

  task automatic t_pwm();
    pwm_wave = 1'b0;
    wr_b(8'hF3); cyc(2);
    chk("R9", "enables not active before trigger", grp0_pins, 4'h7);
    pulse_int();
    chk("R8", "pins 0,1 gated low", grp0_pins, 4'h4);
    pwm_wave = 1'b1; cyc(1);
    chk("R8", "gated pins follow wave high", grp0_pins, 4'h7);
    pwm_wave = 1'b0;
    wr_b(8'hFB); cyc(1);
    chk("R8", "gating before inversion, wave low", grp0_pins, 4'hB);
    pwm_wave = 1'b1; cyc(1);
    chk("R8", "gating before inversion, wave high", grp0_pins, 4'h8);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_int_trigger();
    t_hold();
    t_ext_rise();
    t_ext_fall_both();
    t_mode0();
    t_mode1_uf();
    t_polarity();
    t_pwm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule